// File: doc/BRIEF.md
# Iterative Indexed-Indirect Effective Address Engine

This block resolves the operand address of a 36-bit instruction word before the instruction runs. It takes the word's 18-bit offset and, when the 4-bit index field is nonzero, adds the low half of the named general register. When the indirect flag is set, the engine fetches the word at that address and repeats the same calculation on it. It keeps doing this until it reaches a word with the flag clear. The chain has no fixed depth.

Indirect fetches from addresses 0 to 15 are served by the register file, and all other addresses go to memory through a request/acknowledge port. The result is an 18-bit address or immediate constant, presented with a one-cycle completion pulse. The opcode and register field of the original instruction are presented with it, together with a count of the indirect levels that were followed. An abort input ends a runaway chain.

Top module: `ea_engine`

## Requirements
- R1: Field positions are fixed: opcode in bits 35:27, register field in 26:23, indirect flag in bit 22, index field in 21:18, offset in 17:0. An instruction with the flag clear and index 0 yields its offset as the address, and `op_o`/`acc_o` return bits 35:27 and 26:23 of the started instruction.
- R2: A nonzero index field adds bits 17:0 of that register to the offset, modulo 2^18. An index field of 0 adds nothing, even when register 0 holds a nonzero value.
- R3: With the flag set, the word at the computed address replaces the current one, and its flag, index and offset fields drive the next calculation. Resolution stops at the first word whose flag is clear.
- R4: An indirect fetch from an address below 16 reads register `addr[3:0]` through the register port and raises no memory request. Memory requests never carry an address below 16.
- R5: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`. The data is taken in the cycle `mem_ack_i` is high, and latency may vary.
- R6: `done_o` is high for exactly one cycle per completed resolution, with the final address on `ea_o` in that cycle.
- R7: `level_o` is cleared on start and counts the indirect fetches performed. It holds its value after `done_o`.
- R8: `abort_i` in any busy cycle returns the engine to idle with no `done_o` and no request. It takes priority over an acknowledge and over a final calculation in the same cycle, and the fetched word is discarded without counting.
- R9: `start_i` is accepted only when idle. A start during a resolution changes neither its result nor its opcode output.
- R10: After reset, `done_o`, `mem_req_o`, `level_o` and `ea_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin resolving `instr_i` (idle only) |
| instr_i | input | 36 | Instruction word |
| abort_i | input | 1 | Abandon the current resolution |
| rf_addr_o | output | 4 | Register file read address |
| rf_data_i | input | 36 | Register file read data, same cycle |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 18 | Memory read address |
| mem_ack_i | input | 1 | Memory acknowledge; data valid |
| mem_data_i | input | 36 | Memory read data |
| done_o | output | 1 | One-cycle completion pulse |
| ea_o | output | 18 | Resolved effective address |
| op_o | output | 9 | Opcode of the resolved instruction |
| acc_o | output | 4 | Register field of the resolved instruction |
| level_o | output | LVL_W | Indirect levels followed |

## Verification
Abort can coincide with two events that would otherwise move the engine forward. One is a memory acknowledge, which would load the next word. The other is the final calculation, which would lead to the completion pulse. The bench drives abort in the exact cycle the acknowledge is high. It also drives abort in the cycle right after start, when the engine is doing the last calculation of a direct instruction. In both cases it expects no pulse in the following cycles, no pending request and a level count of zero. A later ordinary resolution must then complete correctly.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W   = 36;
    localparam int ADDR_W   = 18;
    localparam int RIDX_W   = 4;
    localparam int NREGS    = 1 << RIDX_W;
    localparam int OP_W     = 9;
    localparam int IND_BIT  = ADDR_W + RIDX_W;
    localparam int ACC_LSB  = IND_BIT + 1;
    localparam int OP_LSB   = ACC_LSB + RIDX_W;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_RDREG,
        S_MEMRD,
        S_DONE
    } ea_state_e;

    typedef struct packed {
        logic              ind;
        logic [RIDX_W-1:0] idx;
        logic [ADDR_W-1:0] off;
    } ea_fields_t;

    function automatic ea_fields_t split_word(input logic [WORD_W-1:0] w);
        ea_fields_t f;
        f.ind = w[IND_BIT];
        f.idx = w[IND_BIT-1:ADDR_W];
        f.off = w[ADDR_W-1:0];
        return f;
    endfunction
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add
    import ea_pkg::*;
(
    input  ea_fields_t        fld_i,
    input  logic [ADDR_W-1:0] reg_low_i,
    output logic [ADDR_W-1:0] sum_o,
    output logic              is_reg_o
);
    logic [ADDR_W-1:0] addend;

    always_comb begin
        addend   = (fld_i.idx != '0) ? reg_low_i : '0;
        sum_o    = fld_i.off + addend;
        is_reg_o = (sum_o[ADDR_W-1:RIDX_W] == '0);
    end
endmodule

// File: rtl/ea_port_sel.sv
module ea_port_sel
    import ea_pkg::*;
(
    input  ea_state_e         st_i,
    input  logic [RIDX_W-1:0] idx_i,
    input  logic [ADDR_W-1:0] ea_i,
    input  logic [WORD_W-1:0] rf_data_i,
    input  logic [WORD_W-1:0] mem_data_i,
    input  logic              mem_ack_i,
    output logic [RIDX_W-1:0] rf_addr_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output ea_fields_t        fetched_o,
    output logic              fetch_ok_o
);
    logic unused_hi;
    assign unused_hi = ^{rf_data_i[WORD_W-1:IND_BIT+1], mem_data_i[WORD_W-1:IND_BIT+1]};

    always_comb begin
        rf_addr_o  = '0;
        mem_req_o  = 1'b0;
        mem_addr_o = '0;
        fetch_ok_o = 1'b0;
        fetched_o  = split_word(mem_data_i);
        case (st_i)
            S_CALC:  rf_addr_o = idx_i;
            S_RDREG: begin
                rf_addr_o  = ea_i[RIDX_W-1:0];
                fetched_o  = split_word(rf_data_i);
                fetch_ok_o = 1'b1;
            end
            S_MEMRD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ea_i;
                fetch_ok_o = mem_ack_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_engine.sv
module ea_engine
    import ea_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [WORD_W-1:0]    instr_i,
    input  logic                 abort_i,
    output logic [RIDX_W-1:0]    rf_addr_o,
    input  logic [WORD_W-1:0]    rf_data_i,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic                 mem_ack_i,
    input  logic [WORD_W-1:0]    mem_data_i,
    output logic                 done_o,
    output logic [ADDR_W-1:0]    ea_o,
    output logic [OP_W-1:0]      op_o,
    output logic [RIDX_W-1:0]    acc_o,
    output logic [LVL_W-1:0]     level_o
);
    typedef struct packed {
        ea_state_e         st;
        ea_fields_t        fld;
        logic [ADDR_W-1:0] ea;
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] acc;
        logic [LVL_W-1:0]  lvl;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] sum;
    logic              sum_is_reg;
    ea_fields_t        fetched;
    logic              fetch_ok;

    ea_index_add i_add (
        .fld_i     (r_q.fld),
        .reg_low_i (rf_data_i[ADDR_W-1:0]),
        .sum_o     (sum),
        .is_reg_o  (sum_is_reg)
    );

    ea_port_sel i_sel (
        .st_i       (r_q.st),
        .idx_i      (r_q.fld.idx),
        .ea_i       (r_q.ea),
        .rf_data_i  (rf_data_i),
        .mem_data_i (mem_data_i),
        .mem_ack_i  (mem_ack_i),
        .rf_addr_o  (rf_addr_o),
        .mem_req_o  (mem_req_o),
        .mem_addr_o (mem_addr_o),
        .fetched_o  (fetched),
        .fetch_ok_o (fetch_ok)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.fld = split_word(instr_i);
                    r_d.op  = instr_i[WORD_W-1:OP_LSB];
                    r_d.acc = instr_i[OP_LSB-1:ACC_LSB];
                    r_d.lvl = '0;
                    r_d.st  = S_CALC;
                end
            end
            S_CALC: begin
                r_d.ea = sum;
                if (r_q.fld.ind) r_d.st = sum_is_reg ? S_RDREG : S_MEMRD;
                else             r_d.st = S_DONE;
            end
            S_RDREG, S_MEMRD: begin
                if (fetch_ok) begin
                    r_d.fld = fetched;
                    r_d.lvl = r_q.lvl + 1'b1;
                    r_d.st  = S_CALC;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
        if (abort_i && r_q.st != S_IDLE) begin
            r_d     = r_q;
            r_d.st  = S_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: S_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign done_o  = (r_q.st == S_DONE);
    assign ea_o    = r_q.ea;
    assign op_o    = r_q.op;
    assign acc_o   = r_q.acc;
    assign level_o = r_q.lvl;

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !abort_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r4_no_low_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[ADDR_W-1:RIDX_W] != '0));

    a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && r_q.st != S_IDLE) |=> (!done_o && !mem_req_o));

    a_r7_level_calc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CALC) |=> $stable(level_o));

    a_r6_done_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && mem_req_o));
endmodule

// File: tb/test_ea_engine.sv
`timescale 1ns/1ps
module test_ea_engine;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i = 1'b0;
    logic [35:0] instr_i = '0;
    logic        abort_i = 1'b0;
    logic [3:0]  rf_addr_o;
    logic [35:0] rf_data_i;
    logic        mem_req_o;
    logic [17:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [35:0] mem_data_i = '0;
    logic        done_o;
    logic [17:0] ea_o;
    logic [8:0]  op_o;
    logic [3:0]  acc_o;
    logic [7:0]  level_o;

    always #2.5 clk = ~clk;

    logic [35:0] rf [16];
    logic [35:0] mem_m [int];
    assign rf_data_i = rf[rf_addr_o];

    int nchk = 0, nerr = 0, req_cnt = 0, lat = 0;
    bit slow = 0, req_prev = 0;

    ea_engine i_ea_engine (.*);

    function automatic logic [35:0] memrd(input logic [17:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return {18'd0, a ^ 18'h15555};
    endfunction

    function automatic logic [35:0] mk(input logic [8:0] op, input logic [3:0] ac,
                                       input logic ind, input logic [3:0] x, input logic [17:0] off);
        return {op, ac, ind, x, off};
    endfunction

    function automatic logic [17:0] calc(input logic [35:0] w);
        return w[17:0] + ((w[21:18] != 0) ? rf[w[21:18]][17:0] : 18'd0);
    endfunction

    task automatic ref_ea(input logic [35:0] w0, output logic [17:0] ea, output int lvl, output int nreq);
        logic [35:0] w = w0;
        lvl = 0; nreq = 0;
        forever begin
            ea = calc(w);
            if (!w[22] || lvl >= 60) break;
            if (ea[17:4] == 0) w = rf[ea[3:0]];
            else begin w = memrd(ea); nreq++; end
            lvl++;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder with variable latency
    initial begin
        void'($urandom(32'd4242));
        forever begin
            @(negedge clk);
            if (mem_req_o && !mem_ack_i) begin
                if (lat == 0) begin mem_ack_i = 1'b1; mem_data_i = memrd(mem_addr_o); end
                else lat--;
            end else begin
                mem_ack_i = 1'b0;
                lat = slow ? 20 : int'($urandom_range(0, 3));
            end
        end
    end

    always @(posedge clk) begin
        if (mem_req_o && !req_prev) req_cnt++;
        req_prev = mem_req_o;
    end

    task automatic run(input logic [35:0] w, input string req);
        logic [17:0] eea; int elvl, ereq, cyc;
        ref_ea(w, eea, elvl, ereq);
        @(negedge clk); instr_i = w; start_i = 1'b1; req_cnt = 0;
        @(negedge clk); start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 2000) begin @(negedge clk); cyc++; end
        if (!done_o) begin chk(0, req, "timeout waiting done", 0, 1); return; end
        chk(ea_o == eea, req, "ea", ea_o, eea);
        chk(level_o == 8'(elvl), "R7", "level", level_o, elvl);
        chk(req_cnt == ereq, "R4", "memory requests", req_cnt, ereq);
        chk(op_o == w[35:27] && acc_o == w[26:23], "R1", "op/acc", {op_o, acc_o}, w[35:23]);
        @(negedge clk);
        chk(!done_o, "R6", "done width", done_o, 0);
        chk(level_o == 8'(elvl), "R7", "level held", level_o, elvl);
    endtask

    task automatic watch_quiet(input string req);
        bit seen = 0;
        repeat (10) begin @(negedge clk); if (done_o || mem_req_o) seen = 1; end
        chk(!seen, req, "done/request after abort", seen, 0);
        chk(level_o == 0, req, "level after abort", level_o, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!done_o && !mem_req_o && level_o == 0 && ea_o == 0, "R10", "reset outputs",
            {done_o, mem_req_o, level_o, ea_o}, 0);

        // R1 direct
        run(mk(9'h1A5, 4'h7, 0, 0, 18'h2ABCD), "R1");
        // R2 index, zero index ignores r0
        rf[0] = 36'hF_FFFF_FFFF; rf[5] = {18'h3_0000, 18'h00010};
        run(mk(9'h011, 4'h2, 0, 4'd5, 18'd3), "R2");
        run(mk(9'h012, 4'h3, 0, 4'd0, 18'h00444), "R2");
        rf[9] = {18'h0, 18'h3FFFE};
        run(mk(9'h013, 4'h4, 0, 4'd9, 18'd5), "R2");
        // R3 / R5 two-level memory chain
        rf[3] = {18'h1, 18'h00100};
        mem_m[32'h1000] = mk(9'h1FF, 4'hF, 1, 0, 18'h02000);
        mem_m[32'h2000] = mk(9'h0, 4'h0, 0, 4'd3, 18'h00010);
        run(mk(9'h020, 4'h1, 1, 0, 18'h01000), "R3");
        // R4 alias to register file
        rf[7] = mk(9'h1EE, 4'hE, 0, 0, 18'h00777);
        run(mk(9'h021, 4'h6, 1, 0, 18'd7), "R4");
        rf[2] = {18'h0, 18'd4};
        rf[6] = mk(9'h0, 4'h0, 1, 0, 18'h01000);
        run(mk(9'h022, 4'h5, 1, 4'd2, 18'd2), "R4");

        // R8 abort in the acknowledge cycle
        mem_m[32'h5000] = mk(9'h0, 4'h0, 0, 0, 18'h0ABCD);
        @(negedge clk); instr_i = mk(9'h030, 4'h0, 1, 0, 18'h05000); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        begin
            int cyc = 0;
            do begin @(negedge clk); #1; cyc++; end while (!mem_ack_i && cyc < 100);
            chk(mem_ack_i, "R8", "acknowledge reached", mem_ack_i, 1);
        end
        abort_i = 1'b1;
        @(negedge clk); abort_i = 1'b0;
        watch_quiet("R8");
        run(mk(9'h031, 4'h1, 1, 0, 18'h05000), "R8");

        // R8 abort in the final calculation cycle
        @(negedge clk); instr_i = mk(9'h032, 4'h2, 0, 0, 18'h11111); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0; abort_i = 1'b1;
        @(negedge clk); abort_i = 1'b0;
        watch_quiet("R8");
        run(mk(9'h033, 4'h3, 0, 0, 18'h22222), "R8");

        // R9 start while busy is ignored
        slow = 1;
        mem_m[32'h6000] = mk(9'h0, 4'h0, 0, 0, 18'h00123);
        @(negedge clk); instr_i = mk(9'h040, 4'h4, 1, 0, 18'h06000); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_req_o, "R5", "request pending", mem_req_o, 1);
        instr_i = mk(9'h1C1, 4'hC, 0, 0, 18'h3AAAA); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(mem_req_o && mem_addr_o == 18'h06000, "R5", "request held", mem_addr_o, 18'h06000);
        begin
            int cyc = 0;
            while (!done_o && cyc < 200) begin @(negedge clk); cyc++; end
        end
        chk(done_o && ea_o == 18'h00123, "R9", "ea after busy start", ea_o, 18'h00123);
        chk(op_o == 9'h040, "R9", "opcode kept", op_o, 9'h040);
        slow = 0;
        repeat (3) @(negedge clk);

        // random chains
        for (int t = 0; t < 150; t++) begin
            logic [35:0] w0, cur, nxt;
            logic [17:0] a, eea;
            int depth, elvl, ereq;
            mem_m.delete();
            for (int i = 0; i < 16; i++) rf[i] = {$urandom(), $urandom()} & ~(36'h1 << 22);
            depth = $urandom_range(0, 4);
            w0 = mk(9'($urandom()), 4'($urandom()), depth > 0,
                    ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom()), 18'($urandom()));
            cur = w0;
            for (int l = 0; l < depth; l++) begin
                a = calc(cur);
                nxt = mk(9'($urandom()), 4'($urandom()), l < depth - 1,
                         ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom()), 18'($urandom()));
                if (a[17:4] == 0) rf[a[3:0]] = nxt; else mem_m[int'(a)] = nxt;
                cur = nxt;
            end
            ref_ea(w0, eea, elvl, ereq);
            if (elvl < 60) run(w0, "R3");
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule